// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. A load or store unit presents a virtual address. All sixteen entries compare the 20-bit virtual page number at the same time. One cycle later the block answers with a hit and the translated physical address, or with a miss.

A miss also raises a request toward a hardware page walker and hands it the missed page number. When the walk completes, the walker writes the resulting frame number and a small flag field back into the buffer, so a repeat access to the page hits. The fill goes to an entry chosen in this order:
- the entry already holding the same page, if there is one;
- otherwise the lowest-numbered empty entry;
- otherwise an entry picked by a rotating pointer.

A single-cycle invalidate input empties the whole buffer.

The low 12 address bits are never stored. They pass unchanged from the virtual address to the physical address.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `rsp_paddr` equals the stored 20-bit frame number in bits 31:12, followed by bits 11:0 of the request address unchanged (a mapping of page 0x12 to frame 0x64 turns 0x12345 into 0x64345); on a miss `rsp_paddr` and `rsp_flags` are zero.
- R2: The buffer holds 16 entries, all compared in parallel; a lookup hits when any valid entry stores the request's page number (`req_vaddr[31:12]`), and `rsp_flags` then returns that entry's stored flags.
- R3: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high; while it is high exactly one of `rsp_hit` and `rsp_miss` is high, and both are low otherwise. Back-to-back requests give back-to-back responses.
- R4: In the same cycle as `rsp_miss`, `walk_req` is high and `walk_vpn` carries the missed page number; at all other times both are zero.
- R5: A fill (`fill_valid` high at a clock edge) is visible to any lookup issued in a later cycle, and that lookup returns the filled frame and flags.
- R6: A fill of a new page goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry named by a rotating pointer. The pointer is 0 after reset, advances by one (wrapping from 15 to 0) after each such replacement, and is not changed by invalidate.
- R7: A fill whose page number is already stored in a valid entry overwrites that entry, and does not take a second entry or move the pointer.
- R8: `flush_all` high at a clock edge invalidates every entry, so every later lookup misses until refilled; a fill in the same cycle as `flush_all` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_paddr | output | 32 | Physical address on a hit, zero otherwise |
| rsp_flags | output | 4 | Stored flags of the hitting entry |
| walk_req | output | 1 | Miss request toward the page walker |
| walk_vpn | output | 20 | Page number the walker must resolve |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pfn | input | 20 | Physical frame number of the fill |
| fill_flags | input | 4 | Flag field stored with the fill |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The lookup path is tried on the empty buffer, on a buffer filled with sixteen scattered page numbers swept at the lowest, highest and mid-page offsets, on absent pages, and in a back-to-back burst. Together these separate compare errors from offset-merge errors and from pipeline-latency errors.

The fill path is tried in three ways:
- Refilling a resident page shows whether a duplicate entry would wrongly take a slot.
- A run of new pages past capacity exposes the order in which entries are evicted.
- A flush followed by a refill past capacity tells lowest-free placement apart from a pointer-only scheme, because the pointer is left mid-way.

A fill given together with a flush shows whether the flush takes priority.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = 32;
    localparam int PFN_W = PA_W - OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFF_W-1:0] off_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int FLAG_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  vpn_t               lk_vpn,
    input  vpn_t               wr_vpn,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  pfn_t               wr_pfn,
    input  logic [FLAG_W-1:0]  wr_flags,
    input  logic               clr_all,
    output logic [ENTRIES-1:0] lk_match,
    output pfn_t               lk_pfn,
    output logic [FLAG_W-1:0]  lk_flags,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] wr_match
);
    typedef struct packed {
        logic              vld;
        vpn_t              vpn;
        pfn_t              pfn;
        logic [FLAG_W-1:0] flg;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] tab;
    } cam_st_t;

    cam_st_t st_d, st_q;

    // one comparator pair per entry: lookup side and fill side
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]  = st_q.tab[g].vld && (st_q.tab[g].vpn == lk_vpn);
        assign wr_match[g]  = st_q.tab[g].vld && (st_q.tab[g].vpn == wr_vpn);
        assign valid_vec[g] = st_q.tab[g].vld;
    end

    // at most one entry matches, so an OR of masked fields selects it
    always_comb begin
        lk_pfn   = '0;
        lk_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_pfn   = lk_pfn   | st_q.tab[i].pfn;
                lk_flags = lk_flags | st_q.tab[i].flg;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.tab[i].vld = 1'b0;
            end
        end else if (wr_en) begin
            st_d.tab[wr_idx].vld = 1'b1;
            st_d.tab[wr_idx].vpn = wr_vpn;
            st_d.tab[wr_idx].pfn = wr_pfn;
            st_d.tab[wr_idx].flg = wr_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: duplicates never form, so a lookup matches at most one entry
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8: invalidate empties the whole array on the next cycle
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_vec == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic               fill_go,
    output logic [IDX_W-1:0]   victim_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] rr;
    } vic_st_t;

    vic_st_t st_d, st_q;

    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_dup;
    logic             any_free;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (dup_vec[i])    dup_idx  = IDX_W'(i);
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
        any_dup  = |dup_vec;
        any_free = ~&valid_vec;
    end

    always_comb begin
        st_d = st_q;
        if (any_dup) begin
            victim_idx = dup_idx;
        end else if (any_free) begin
            victim_idx = free_idx;
        end else begin
            victim_idx = st_q.rr;
            if (fill_go) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a new page never displaces a valid entry while a free one exists
    a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !any_dup && any_free) |-> !valid_vec[victim_idx]);

    // R7: a resident page is refilled in place
    a_r7_dup_in_place: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && any_dup) |-> dup_vec[victim_idx]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int FLAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [31:0]       rsp_paddr,
    output logic [FLAG_W-1:0] rsp_flags,
    output logic              walk_req,
    output logic [19:0]       walk_vpn,
    input  logic              fill_valid,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_pfn,
    input  logic [FLAG_W-1:0] fill_flags,
    input  logic              flush_all
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              miss;
        logic [PA_W-1:0]   paddr;
        logic [FLAG_W-1:0] flags;
        logic              walk;
        vpn_t              wvpn;
    } rsp_st_t;

    rsp_st_t st_d, st_q;

    vpn_t               lk_vpn;
    off_t               lk_off;
    logic [ENTRIES-1:0] lk_match;
    pfn_t               lk_pfn;
    logic [FLAG_W-1:0]  lk_flags;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] dup_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_go;

    assign lk_vpn  = req_vaddr[VA_W-1:OFF_W];
    assign lk_off  = req_vaddr[OFF_W-1:0];
    assign fill_go = fill_valid && !flush_all;

    xlat_cam #(
        .ENTRIES (ENTRIES),
        .FLAG_W  (FLAG_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .wr_vpn    (fill_vpn),
        .wr_en     (fill_go),
        .wr_idx    (victim_idx),
        .wr_pfn    (fill_pfn),
        .wr_flags  (fill_flags),
        .clr_all   (flush_all),
        .lk_match  (lk_match),
        .lk_pfn    (lk_pfn),
        .lk_flags  (lk_flags),
        .valid_vec (valid_vec),
        .wr_match  (dup_vec)
    );

    xlat_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .dup_vec    (dup_vec),
        .fill_go    (fill_go),
        .victim_idx (victim_idx)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.vld = 1'b1;
            if (|lk_match) begin
                st_d.hit   = 1'b1;
                st_d.paddr = {lk_pfn, lk_off};
                st_d.flags = lk_flags;
            end else begin
                st_d.miss = 1'b1;
                st_d.walk = 1'b1;
                st_d.wvpn = lk_vpn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.miss;
    assign rsp_paddr = st_q.paddr;
    assign rsp_flags = st_q.flags;
    assign walk_req  = st_q.walk;
    assign walk_vpn  = st_q.wvpn;

    // R3: one-cycle registered response
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    // R4: the walker is asked exactly when a miss is reported
    a_r4_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req == rsp_miss);
    a_r4_walk_vpn: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!walk_req || walk_vpn == $past(req_vaddr[31:12])));

    // R1: offset bits pass straight through on a hit
    a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(req_vaddr[11:0])));
endmodule

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        rsp_valid, rsp_hit, rsp_miss, walk_req;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_flags;
    logic [19:0] walk_vpn;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_pfn;
    logic [3:0]  fill_flags;
    logic        flush_all;

    always #2.5 clk = ~clk;

    xlat_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_flags(fill_flags), .flush_all(flush_all)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model built from the requirements
    bit          m_vld [16];
    logic [19:0] m_vpn [16];
    logic [19:0] m_pfn [16];
    logic [3:0]  m_flg [16];
    int          m_rr = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] f);
        int slot = -1;
        for (int i = 0; i < 16; i++) if (slot < 0 && m_vld[i] && m_vpn[i] == v) slot = i;   // R7
        if (slot < 0) for (int i = 0; i < 16; i++) if (slot < 0 && !m_vld[i]) slot = i;     // R6 free
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 16;
        end
        m_vld[slot] = 1'b1; m_vpn[slot] = v; m_pfn[slot] = p; m_flg[slot] = f;
    endfunction

    // packed view {valid,hit,miss,walk,flags,paddr,walk_vpn}
    function automatic logic [59:0] expect_of(input logic [31:0] va);
        logic [59:0] e;
        e = {1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 32'h0, va[31:12]};
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_vpn[i] == va[31:12])
                e = {1'b1, 1'b1, 1'b0, 1'b0, m_flg[i], m_pfn[i], va[11:0], 20'h0};
        return e;
    endfunction

    function automatic logic [59:0] observed();
        return {rsp_valid, rsp_hit, rsp_miss, walk_req, rsp_flags, rsp_paddr, walk_vpn};
    endfunction

    task automatic lookup(input logic [31:0] va, input string req);
        logic [59:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        e = expect_of(va);
        check(observed() == e, req, 64'(observed()), 64'(e));
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] f, input bit fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_flags = f; flush_all = fl;
        @(negedge clk);
        fill_valid = 1'b0; flush_all = 1'b0;
        if (fl) for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;   // R8 flush wins
        else model_fill(v, p, f);
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    endtask

    function automatic logic [19:0] base_vpn(input int i);
        return (i == 0) ? 20'h00012 : 20'(32'h100 + i * 7);
    endfunction

    task automatic sweep_known(input string req);
        for (int i = 0; i < 16; i++) lookup({base_vpn(i), 12'(i * 37)}, req);
        for (int j = 0; j < 24; j++) lookup({20'(32'h800 + j), 12'hABC}, req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_flags = '0; flush_all = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4: reset state quiet
        check(observed() == 60'h0, "R3 reset", 64'(observed()), 64'h0);

        // R4: empty buffer misses and asks the walker
        lookup(32'h0001_2345, "R4 empty miss");

        // R1 R5: the worked example
        fill(20'h00012, 20'h00064, 4'h5, 1'b0);
        lookup(32'h0001_2345, "R1 example");
        check(rsp_paddr == 32'h0006_4345, "R1 example paddr", 64'(rsp_paddr), 64'h64345);

        // R2 R5 R6: fill the remaining 15 entries
        for (int i = 1; i < 16; i++)
            fill(base_vpn(i), 20'hA0000 ^ 20'(i * 32'h111), 4'(i), 1'b0);
        for (int i = 0; i < 16; i++) begin
            lookup({base_vpn(i), 12'h000}, "R2 full low offset");
            lookup({base_vpn(i), 12'hFFF}, "R1 full high offset");
            lookup({base_vpn(i), 12'(i * 32'h123)}, "R2 full mid offset");
        end
        for (int j = 0; j < 6; j++) lookup({20'(32'hF000 + j), 12'h010}, "R2 absent page");

        // R7: refill a resident page in place
        fill(20'h00012, 20'h55555, 4'hF, 1'b0);
        lookup(32'h0001_2ABC, "R7 overwrite");
        // R6: new pages replace by rotating pointer; R7 means page 0x12 holds slot 0
        for (int j = 0; j < 20; j++) begin
            fill(20'(32'h800 + j), 20'(32'hC0000 + j * 3), 4'(j), 1'b0);
            lookup({20'(32'h800 + j), 12'h321}, "R6 new fill hits");
        end
        sweep_known("R6 eviction order");

        // R8: flush, and flush together with fill
        flush();
        sweep_known("R8 after flush");
        fill(20'h00777, 20'h12345, 4'h3, 1'b1);
        lookup(32'h0077_7000, "R8 fill dropped by flush");

        // R6: after flush, free slots first, then pointer left mid-way
        for (int i = 0; i < 16; i++) fill(base_vpn(i), 20'(32'h30000 + i), 4'(15 - i), 1'b0);
        for (int j = 0; j < 3; j++) fill(20'(32'h800 + j), 20'(32'h40000 + j), 4'h9, 1'b0);
        sweep_known("R6 free first then pointer");

        // R3: back-to-back requests
        begin
            logic [31:0] prev_va;
            logic [59:0] e;
            for (int k = 0; k <= 12; k++) begin
                @(negedge clk);
                if (k > 0) begin
                    e = expect_of(prev_va);
                    check(observed() == e, "R3 back-to-back", 64'(observed()), 64'(e));
                end
                if (k < 12) begin
                    prev_va = (k % 2 == 0) ? {base_vpn(k), 12'(k * 32'h51)} : {20'(32'hF100 + k), 12'h0};
                    req_valid = 1'b1; req_vaddr = prev_va;
                end else begin
                    req_valid = 1'b0;
                end
            end
            @(negedge clk);
            check(observed() == 60'h0, "R3 idle after burst", 64'(observed()), 64'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule